// File: doc/BRIEF.md
# Demultiplexing Acquisition Record Controller

This block takes a stream of 8-bit samples that an upstream converter delivers two at a time. It spreads them across eight memory banks that are written in parallel. Four accepted sample pairs fill one eight-sample line. The complete line is then written to all eight banks at once, at one shared bank address. Each bank therefore sees a write only once per four input clocks, which is one eighth of the sample rate. A synchronous, presettable counter supplies the shared bank address. The eight banks of 2^13 words each together hold a record of 2^16 samples.

Software or a trigger unit pulses the arm input together with a preset bank address. Capture then starts at that address with the demux phase cleared, so the first sample after arming always lands in bank 0. When the counter comes back around to the preset value, the record is complete. The done flag then rises and further samples are ignored until the next arm.

The controller is a three-state machine:
- IDLE is the state after reset. Pairs are ignored.
- FILL collects pairs and writes lines.
- DONE means the record is complete. Pairs are ignored.

It has four transitions:
- IDLE→FILL on arm.
- FILL→FILL on arm, which restarts the record.
- FILL→DONE when the line written at the last address before the preset completes.
- DONE→FILL on arm.

Top module: `acq_record_ctrl`

## Requirements
- R1: After reset, `wr_en_o` is all zero, `done_o` is low and the block is in IDLE. Sample pairs presented before the first arm cause no write.
- R2: Within `pair_i`, bits [7:0] hold the earlier sample of the pair and bits [15:8] hold the later one.
- R3: The k-th sample accepted since the last arm (k counted from 0) is written to bank k mod 8. Bank b's data sits in `wr_data_o[8b+7:8b]`.
- R4: All eight bits of `wr_en_o` assert together, for exactly one cycle, in the cycle after the fourth pair of a line is accepted. No other write happens.
- R5: The line holding sample k is written at bank address (preset + floor(k/8)) mod 8192, on `wr_addr_o`.
- R6: A cycle with `pair_valid_i` low contributes no sample and does not advance the demux phase.
- R7: Arm loads the preset, clears the demux phase and discards a partly filled line. A pair presented in the arm cycle itself is ignored.
- R8: After 8192 lines the address returns to the preset. `done_o` then rises in the same cycle as the final write, and no further write occurs while in DONE.
- R9: Arm in DONE clears `done_o` and starts a new record at the new preset.
- R10: `wr_data_o` and `wr_addr_o` hold their values in the cycle after a write pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-pair clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | Start or restart a record; loads the preset |
| preset_i | input | 13 | Starting bank address, sampled on arm |
| pair_valid_i | input | 1 | A sample pair is present on `pair_i` |
| pair_i | input | 16 | Two samples, the earlier one in the low byte |
| wr_en_o | output | 8 | Per-bank write enables |
| wr_addr_o | output | 13 | Shared bank address |
| wr_data_o | output | 64 | Bank b data in bits [8b+7:8b] |
| done_o | output | 1 | Record complete |

## Verification
The main function is tried with five input patterns, each of which separates different faults:
- **Back-to-back pairs with distinct bytes** expose swapped lanes, a wrong bank order or a line written a cycle early or late.
- **Pairs with idle gaps** show whether an empty cycle is wrongly taken as a sample.
- **Arming in the middle of a line, with a junk pair in the arm cycle,** shows whether stale phase, stale data or the arm-cycle pair leak into the next line.
- **A full record preset near the top of the address space** checks the address wrap, the exact moment `done_o` rises and that later pairs produce nothing.
- **Re-arming from DONE** shows that a second record starts cleanly.

// File: rtl/acq_pkg.sv
package acq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_DONE = 2'd2
    } acq_state_t;

endpackage

// File: rtl/acq_addr_gen.sv
module acq_addr_gen #(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] preset_i,
    input  logic          step_i,
    output logic [AW-1:0] addr_o,
    output logic          last_o
);

    logic [AW-1:0] addr_q;
    logic [AW-1:0] start_q;
    logic [AW-1:0] addr_nxt;

    assign addr_nxt = addr_q + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            start_q <= '0;
        end else if (load_i) begin
            addr_q  <= preset_i;
            start_q <= preset_i;
        end else if (step_i) begin
            addr_q <= addr_nxt;
        end
    end

    assign addr_o = addr_q;
    assign last_o = (addr_nxt == start_q);

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && !load_i |=> addr_o == AW'($past(addr_o) + 1'b1)); // R5

    AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> addr_o == $past(preset_i)); // R7

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i && !step_i |=> $stable(addr_o)); // R5

endmodule

// File: rtl/acq_line_demux.sv
module acq_line_demux #(
    parameter int SAMPLE_W = 8,
    parameter int LANES    = 2,
    parameter int DEMUX    = 4,
    localparam int PAIR_W  = LANES * SAMPLE_W,
    localparam int LINE_W  = PAIR_W * DEMUX,
    localparam int PW      = (DEMUX > 1) ? $clog2(DEMUX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              take_i,
    input  logic [PAIR_W-1:0] pair_i,
    output logic              line_full_o,
    output logic [LINE_W-1:0] line_o
);

    localparam logic [PW-1:0] LAST_PH = PW'(DEMUX - 1);

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (clr_i) begin
            phase_q <= '0;
        end else if (take_i) begin
            phase_q <= (phase_q == LAST_PH) ? '0 : phase_q + 1'b1;
        end
    end

    assign line_full_o = take_i && (phase_q == LAST_PH);

    for (genvar g = 0; g < DEMUX; g++) begin : g_slot
        if (g < DEMUX - 1) begin : g_held
            logic [PAIR_W-1:0] slot_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    slot_q <= '0;
                end else if (take_i && (phase_q == PW'(g))) begin
                    slot_q <= pair_i;
                end
            end
            assign line_o[g*PAIR_W +: PAIR_W] = slot_q;
        end else begin : g_live
            assign line_o[g*PAIR_W +: PAIR_W] = pair_i;
        end
    end

    AST_PHASE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> phase_q == '0); // R7

    AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i && !take_i |=> $stable(phase_q)); // R6

    AST_PHASE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i && take_i && !line_full_o |=> phase_q == PW'($past(phase_q) + 1'b1)); // R4

endmodule

// File: rtl/acq_ctrl_fsm.sv
module acq_ctrl_fsm
    import acq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic pair_valid_i,
    input  logic line_full_i,
    input  logic last_i,
    output logic take_o,
    output logic done_o
);

    acq_state_t state_q;
    acq_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (arm_i) state_d = ST_FILL;
            ST_FILL: begin
                if (arm_i) begin
                    state_d = ST_FILL;
                end else if (line_full_i && last_i) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: if (arm_i) state_d = ST_FILL;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        take_o = (state_q == ST_FILL) && pair_valid_i && !arm_i;
        done_o = (state_q == ST_DONE);
    end

    AST_IDLE_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != ST_FILL |-> !take_o); // R1

    AST_ARM_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> state_q == ST_FILL); // R9

endmodule

// File: rtl/acq_record_ctrl.sv
module acq_record_ctrl #(
    parameter int SAMPLE_W  = 8,
    parameter int REC_AW    = 16,
    parameter int LANES     = 2,
    parameter int DEMUX     = 4,
    localparam int NBANK    = LANES * DEMUX,
    localparam int BANK_AW  = REC_AW - $clog2(NBANK),
    localparam int PAIR_W   = LANES * SAMPLE_W,
    localparam int LINE_W   = NBANK * SAMPLE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm_i,
    input  logic [BANK_AW-1:0] preset_i,
    input  logic               pair_valid_i,
    input  logic [PAIR_W-1:0]  pair_i,
    output logic [NBANK-1:0]   wr_en_o,
    output logic [BANK_AW-1:0] wr_addr_o,
    output logic [LINE_W-1:0]  wr_data_o,
    output logic               done_o
);

    logic               take;
    logic               line_full;
    logic [LINE_W-1:0]  line;
    logic [BANK_AW-1:0] addr;
    logic               addr_last;

    acq_ctrl_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .arm_i        (arm_i),
        .pair_valid_i (pair_valid_i),
        .line_full_i  (line_full),
        .last_i       (addr_last),
        .take_o       (take),
        .done_o       (done_o)
    );

    acq_line_demux #(
        .SAMPLE_W (SAMPLE_W),
        .LANES    (LANES),
        .DEMUX    (DEMUX)
    ) u_demux (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (arm_i),
        .take_i      (take),
        .pair_i      (pair_i),
        .line_full_o (line_full),
        .line_o      (line)
    );

    acq_addr_gen #(
        .AW (BANK_AW)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (arm_i),
        .preset_i (preset_i),
        .step_i   (line_full),
        .addr_o   (addr),
        .last_o   (addr_last)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en_o   <= '0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
        end else if (line_full) begin
            wr_en_o   <= '1;
            wr_addr_o <= addr;
            wr_data_o <= line;
        end else begin
            wr_en_o   <= '0;
        end
    end

    AST_BANKS_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o == '0) || (wr_en_o == '1)); // R4

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o != '0) |=> (wr_en_o == '0)); // R4

    AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o != '0) |=> $stable(wr_data_o) && $stable(wr_addr_o)); // R10

    AST_QUIET_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && $past(done_o) |-> (wr_en_o == '0)); // R8

endmodule

// File: tb/sim_acq_record_ctrl.sv
`timescale 1ns/1ps
module sim_acq_record_ctrl;

    localparam int SW  = 8;
    localparam int NB  = 8;
    localparam int BAW = 13;
    localparam int EW  = BAW + NB * SW;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           arm = 1'b0;
    logic [BAW-1:0] preset = '0;
    logic           pair_valid = 1'b0;
    logic [15:0]    pair = '0;
    logic [NB-1:0]  wr_en;
    logic [BAW-1:0] wr_addr;
    logic [NB*SW-1:0] wr_data;
    logic           done;

    always #2.5 clk = ~clk;

    acq_record_ctrl u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .arm_i        (arm),
        .preset_i     (preset),
        .pair_valid_i (pair_valid),
        .pair_i       (pair),
        .wr_en_o      (wr_en),
        .wr_addr_o    (wr_addr),
        .wr_data_o    (wr_data),
        .done_o       (done)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [EW-1:0] expq[$];

    // reference model state
    bit             m_act = 1'b0;
    int             m_ph = 0;
    logic [63:0]    m_line = '0;
    logic [BAW-1:0] m_addr = '0;
    logic [BAW-1:0] m_pre = '0;

    task automatic chk(input bit ok, input string req, input logic [EW-1:0] act, input logic [EW-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_take(input logic [15:0] p);
        if (m_act) begin
            m_line[m_ph*16 +: 16] = p;
            m_ph++;
            if (m_ph == 4) begin
                expq.push_back({m_addr, m_line});
                m_addr = m_addr + 1'b1;
                m_ph = 0;
                if (m_addr == m_pre) m_act = 1'b0;
            end
        end
    endtask

    task automatic send(input logic [15:0] p);
        @(negedge clk);
        arm = 1'b0; pair_valid = 1'b1; pair = p;
        model_take(p);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            arm = 1'b0; pair_valid = 1'b0;
        end
    endtask

    task automatic do_arm(input logic [BAW-1:0] pre, input bit junk);
        @(negedge clk);
        arm = 1'b1; preset = pre; pair_valid = junk; pair = 16'hDEAD;
        m_act = 1'b1; m_ph = 0; m_pre = pre; m_addr = pre; m_line = '0;
    endtask

    // monitor: pops expected writes and checks hold after each pulse
    bit            prev_we = 1'b0;
    logic [EW-1:0] held = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_en != '0) begin
                chk(wr_en == '1, "R4 all banks together", EW'(wr_en), EW'({NB{1'b1}}));
                if (expq.size() == 0) begin
                    chk(1'b0, "R1/R8 unexpected write", {wr_addr, wr_data}, '0);
                end else begin
                    logic [EW-1:0] e;
                    e = expq.pop_front();
                    chk({wr_addr, wr_data} == e, "R2/R3/R5 line content", {wr_addr, wr_data}, e);
                end
                held = {wr_addr, wr_data};
                prev_we = 1'b1;
            end else begin
                if (prev_we) chk({wr_addr, wr_data} == held, "R10 hold after pulse", {wr_addr, wr_data}, held);
                prev_we = 1'b0;
            end
        end
    end

    initial begin
        #(200000 * 5);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(wr_en == '0, "R1 reset wr_en", EW'(wr_en), '0);
        chk(done == 1'b0, "R1 reset done", EW'(done), '0);
        // R1: pairs before arm are ignored
        for (int i = 0; i < 8; i++) send(16'h1100 + 16'(i));
        idle(2);
        chk(wr_en == '0 && done == 1'b0, "R1 idle ignores pairs", EW'(wr_en), '0);

        // R2 R3 R4 R5: back-to-back lines
        do_arm(13'd5, 1'b0);
        for (int i = 0; i < 12; i++) send({8'(2*i+1) ^ 8'hA0, 8'(2*i) ^ 8'h30});
        idle(3);

        // R6: gaps between pairs
        send(16'h0201); idle(2); send(16'h0403); idle(1); send(16'h0605); send(16'h0807);
        idle(3);

        // R7: arm mid-line with a junk pair in the arm cycle
        do_arm(13'd20, 1'b0);
        send(16'hEEEE); send(16'hFFFF);
        do_arm(13'd40, 1'b1);
        send(16'h2211); send(16'h4433); send(16'h6655); send(16'h8877);
        idle(3);

        // R8: full record wrapping through the top of the address space
        do_arm(13'h1FFE, 1'b0);
        for (int i = 0; i < 32768; i++) begin
            send(16'(i * 40503 + 7));
            if (i == 32767) begin
                idle(1);
                chk(done == 1'b1, "R8 done with last write", EW'(done), EW'(1));
            end else if (i == 32763) begin
                @(posedge clk);
                chk(done == 1'b0, "R8 done not early", EW'(done), '0);
            end
        end
        for (int i = 0; i < 8; i++) send(16'hABCD);
        idle(2);
        chk(done == 1'b1 && wr_en == '0, "R8 quiet in done", EW'({wr_en, done}), EW'(1));

        // R9: re-arm from done
        do_arm(13'd3, 1'b0);
        send(16'h1111); send(16'h2222); send(16'h3333); send(16'h4444);
        idle(2);
        chk(done == 1'b0, "R9 done cleared by arm", EW'(done), '0);

        idle(3);
        chk(expq.size() == 0, "R4 every expected write seen", EW'(expq.size()), '0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule